// File: doc/BRIEF.md
# Compare and Conditional Branch Unit

This block keeps a five-bit flag register that records how two 32-bit operands compare, and uses those flags to resolve 16-bit conditional branch instructions. A compare strobe loads the flags from the two operands on the next clock edge. A resolve strobe presents a branch instruction and the address it was fetched from. In that same cycle, and without a clock edge, the block returns whether the branch is taken, the address to fetch next, and whether the instruction is illegal.

The flags record equality apart from ordering. When the operands differ, the signed ordering and the unsigned ordering are recorded independently. A branch instruction carries a four-bit condition selector and a signed ten-bit offset. The offset counts halfwords from the address that follows the two-byte branch.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset all five flags are zero. Every condition except not-equal (selector 1) therefore resolves as not taken, and not-equal resolves as taken.
- R2: A compare of equal operands leaves only the equal flag (bit 2) set. The flag register keeps bit 0 for signed greater, bit 1 for signed less, bit 3 for unsigned greater and bit 4 for unsigned less.
- R3: A compare of unequal operands sets exactly one of the signed pair (bit 1 if A < B as two's complement, else bit 0). It also sets exactly one of the unsigned pair (bit 4 if A < B unsigned, else bit 3), chosen independently of the signed pair.
- R4: A branch is a word whose bits 15 and 14 are both 1. Its selector is bits 13:10 and picks the condition: 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater.
- R5: Selectors 6 to 9 are the or-equal forms: signed greater-or-equal, signed less-or-equal, unsigned greater-or-equal and unsigned less-or-equal. Each is taken when its ordering flag or the equal flag is set.
- R6: A taken branch sets the next PC to the branch address + 2 + 2 × (bits 9:0 read as a signed ten-bit value), modulo 2^32.
- R7: A legal branch that is not taken sets the next PC to the branch address + 2.
- R8: Selectors 10 to 15 raise the illegal flag, are not taken, produce the branch address + 2 as the next PC, and leave the flag register unchanged.
- R9: A resolve of a word whose bits 15:14 are not both 1 raises the illegal flag and is not taken.
- R10: With the resolve strobe low, the taken and illegal outputs are low and the next PC is the branch address + 2.
- R11: When a compare and a resolve fall in the same cycle, the resolve uses the flags from before the compare. The new flags apply from the following cycle.
- R12: Without a compare strobe the flag register holds its value, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpValid | input | 1 | Load the flags from the operands at the next edge |
| opndA | input | 32 | First compare operand |
| opndB | input | 32 | Second compare operand |
| resolveValid | input | 1 | Resolve the presented branch this cycle |
| brInstr | input | 16 | Branch instruction word |
| brAddr | input | 32 | Fetch address of the branch |
| brTaken | output | 1 | Branch taken this cycle |
| nextPc | output | 32 | Address to fetch next |
| illegalOp | output | 1 | Presented word is not a legal branch |

## Verification
Assertions check the following on every cycle:
- The flag register stays in a consistent shape: equal stands alone, or else one bit is set in each ordering pair.
- Equal operands load the equal-only pattern.
- The flags hold when no compare strobe is given.
- The taken and illegal outputs are mutually exclusive, and both stay quiet without a resolve.
- A non-branch word is flagged as illegal.
- Not-equal agrees with the equal flag.

The bench's scenarios are needed for the rest: the offset arithmetic at its extremes and at the 32-bit wrap, the decode of every selector, the old-flag ordering when a compare and a resolve share a cycle, and the fact that illegal resolves leave the flags unchanged. The last of these is seen only through the branches that follow.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  localparam int CC_W = 5;

  // flag bit positions; branch conditions decode these
  localparam int CC_SGT = 0;
  localparam int CC_SLT = 1;
  localparam int CC_EQ  = 2;
  localparam int CC_UGT = 3;
  localparam int CC_ULT = 4;

  localparam int INSTR_W  = 16;
  localparam int SEL_LO   = 10;
  localparam int SEL_W    = 4;
  localparam int OFF_W    = 10;
  localparam int LAST_SEL = 9;

  typedef enum logic [SEL_W-1:0] {
    SEL_EQ  = 4'd0,
    SEL_NE  = 4'd1,
    SEL_SLT = 4'd2,
    SEL_SGT = 4'd3,
    SEL_ULT = 4'd4,
    SEL_UGT = 4'd5,
    SEL_SGE = 4'd6,
    SEL_SLE = 4'd7,
    SEL_UGE = 4'd8,
    SEL_ULE = 4'd9
  } condSel_e;

  typedef struct packed {
    logic ccLoad;     // capture compare result at next edge
    logic useOffset;  // add scaled offset to sequential PC
  } cbuStrobes_t;

endpackage

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
  import cbu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmpValid,
  input  logic                 resolveValid,
  input  logic [1:0]           formBits,
  input  logic [SEL_W-1:0]     condField,
  input  logic [CC_W-1:0]      ccQ,
  output cbuStrobes_t          strobes,
  output logic                 brTaken,
  output logic                 illegalOp
);

  logic isBranch;
  logic selLegal;
  logic condTrue;

  assign isBranch = &formBits;
  assign selLegal = (condField <= SEL_W'(LAST_SEL));

  always_comb begin
    condTrue = 1'b0;
    unique case (condField)
      SEL_EQ:  condTrue = ccQ[CC_EQ];
      SEL_NE:  condTrue = !ccQ[CC_EQ];
      SEL_SLT: condTrue = ccQ[CC_SLT];
      SEL_SGT: condTrue = ccQ[CC_SGT];
      SEL_ULT: condTrue = ccQ[CC_ULT];
      SEL_UGT: condTrue = ccQ[CC_UGT];
      SEL_SGE: condTrue = ccQ[CC_SGT] | ccQ[CC_EQ];
      SEL_SLE: condTrue = ccQ[CC_SLT] | ccQ[CC_EQ];
      SEL_UGE: condTrue = ccQ[CC_UGT] | ccQ[CC_EQ];
      SEL_ULE: condTrue = ccQ[CC_ULT] | ccQ[CC_EQ];
      default: condTrue = 1'b0;
    endcase
  end

  assign illegalOp         = resolveValid & !(isBranch & selLegal);
  assign brTaken           = resolveValid & isBranch & selLegal & condTrue;
  assign strobes.ccLoad    = cmpValid;
  assign strobes.useOffset = brTaken;

  // R10: outputs stay quiet without a resolve request
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |-> (!brTaken && !illegalOp));

  // R8: a resolve is never both taken and illegal
  p_taken_illegal_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(brTaken && illegalOp));

  // R9: non-branch words are rejected
  p_nonbranch_illegal_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && formBits != 2'b11) |-> illegalOp);

  // R4: not-equal follows the equal flag
  p_ne_tracks_eq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && formBits == 2'b11 && condField == SEL_NE) |-> (brTaken == !ccQ[CC_EQ]));

endmodule

// File: rtl/cbu_datapath.sv
module cbu_datapath
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  opndA,
  input  logic [DATA_W-1:0]  opndB,
  input  logic [ADDR_W-1:0]  brAddr,
  input  logic [OFF_W-1:0]   offField,
  input  cbuStrobes_t        strobes,
  output logic [CC_W-1:0]    ccQ,
  output logic [ADDR_W-1:0]  nextPc
);

  localparam int EXT_W = ADDR_W - OFF_W - 1;
  localparam logic [ADDR_W-1:0] INSTR_BYTES = ADDR_W'(INSTR_W / 8);

  logic [CC_W-1:0]   ccNext;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] offBytes;

  always_comb begin
    ccNext = '0;
    if (opndA == opndB) begin
      ccNext[CC_EQ] = 1'b1;
    end else begin
      if ($signed(opndA) < $signed(opndB)) ccNext[CC_SLT] = 1'b1;
      else                                 ccNext[CC_SGT] = 1'b1;
      if (opndA < opndB) ccNext[CC_ULT] = 1'b1;
      else               ccNext[CC_UGT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ccQ <= '0;
    else if (strobes.ccLoad) ccQ <= ccNext;
  end

  assign seqPc    = brAddr + INSTR_BYTES;
  assign offBytes = {{EXT_W{offField[OFF_W-1]}}, offField, 1'b0};
  assign nextPc   = strobes.useOffset ? (seqPc + offBytes) : seqPc;

  // R2: equal stands alone in the flag register
  p_eq_alone_r2: assert property (@(posedge clk) disable iff (!rstN)
    ccQ[CC_EQ] |-> (ccQ == CC_W'(1 << CC_EQ)));

  // R2: equal operands load the equal-only pattern
  p_eq_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ccLoad && opndA == opndB) |=> (ccQ == CC_W'(1 << CC_EQ)));

  // R3: unequal result carries one bit per ordering pair
  p_pairs_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ccQ != '0 && !ccQ[CC_EQ]) |->
      ($countones({ccQ[CC_SGT], ccQ[CC_SLT]}) == 1 && $countones({ccQ[CC_UGT], ccQ[CC_ULT]}) == 1));

  // R12: flags hold without a compare
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ccLoad |=> $stable(ccQ));

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmpValid,
  input  logic [DATA_W-1:0]  opndA,
  input  logic [DATA_W-1:0]  opndB,
  input  logic               resolveValid,
  input  logic [15:0]        brInstr,
  input  logic [ADDR_W-1:0]  brAddr,
  output logic               brTaken,
  output logic [ADDR_W-1:0]  nextPc,
  output logic               illegalOp
);

  cbuStrobes_t     strobes;
  logic [CC_W-1:0] ccQ;

  cbu_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmpValid     (cmpValid),
    .resolveValid (resolveValid),
    .formBits     (brInstr[INSTR_W-1:INSTR_W-2]),
    .condField    (brInstr[SEL_LO+SEL_W-1:SEL_LO]),
    .ccQ          (ccQ),
    .strobes      (strobes),
    .brTaken      (brTaken),
    .illegalOp    (illegalOp)
  );

  cbu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opndA    (opndA),
    .opndB    (opndB),
    .brAddr   (brAddr),
    .offField (brInstr[OFF_W-1:0]),
    .strobes  (strobes),
    .ccQ      (ccQ),
    .nextPc   (nextPc)
  );

endmodule

// File: tb/cmp_branch_unit_tb_top.sv
module cmp_branch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpValid = 1'b0;
  logic [31:0] opndA = '0;
  logic [31:0] opndB = '0;
  logic        resolveValid = 1'b0;
  logic [15:0] brInstr = '0;
  logic [31:0] brAddr = '0;
  logic        brTaken;
  logic [31:0] nextPc;
  logic        illegalOp;

  int checks = 0;
  int failures = 0;
  int mFlags = 0;   // model flags: 1 sgt, 2 slt, 4 eq, 8 ugt, 16 ult

  always #4 clk = ~clk;

  cmp_branch_unit dut_i (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .opndA(opndA), .opndB(opndB),
    .resolveValid(resolveValid), .brInstr(brInstr), .brAddr(brAddr),
    .brTaken(brTaken), .nextPc(nextPc), .illegalOp(illegalOp)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) mFlags <= 0;
    else if (cmpValid) begin
      if (opndA == opndB) mFlags <= 4;
      else mFlags <= (($signed(opndA) < $signed(opndB)) ? 2 : 1) | ((opndA < opndB) ? 16 : 8);
    end
  end

  function automatic logic condHolds(input int sel, input int f);
    case (sel)
      0: return (f & 4) != 0;
      1: return (f & 4) == 0;
      2: return (f & 2) != 0;
      3: return (f & 1) != 0;
      4: return (f & 16) != 0;
      5: return (f & 8) != 0;
      6: return (f & 5) != 0;
      7: return (f & 6) != 0;
      8: return (f & 12) != 0;
      9: return (f & 20) != 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic cv, input logic [31:0] a, input logic [31:0] b,
                      input logic rv, input logic [15:0] ins, input logic [31:0] addr,
                      input string tag);
    logic expT, expI;
    logic [31:0] expPc;
    int sel, off;
    @(negedge clk);
    cmpValid = cv; opndA = a; opndB = b;
    resolveValid = rv; brInstr = ins; brAddr = addr;
    #1;
    sel = int'(ins[13:10]);
    off = ins[9] ? int'(ins[9:0]) - 1024 : int'(ins[9:0]);
    expT = 1'b0; expI = 1'b0;
    expPc = addr + 32'd2;
    if (rv) begin
      if (ins[15:14] != 2'b11 || sel > 9) expI = 1'b1;
      else if (condHolds(sel, mFlags)) begin
        expT = 1'b1;
        expPc = addr + 32'd2 + 32'(off * 2);
      end
    end
    checks++;
    if (brTaken !== expT || illegalOp !== expI || nextPc !== expPc) begin
      failures++;
      $display("FAIL %s: taken=%b illegal=%b pc=%h expected taken=%b illegal=%b pc=%h",
               tag, brTaken, illegalOp, nextPc, expT, expI, expPc);
    end
  endtask

  function automatic logic [15:0] br(input int sel, input int off);
    return {2'b11, 4'(sel), 10'(off)};
  endfunction

  task automatic sweep(input logic [31:0] addr, input string tag);
    for (int s = 0; s < 10; s++) step(1'b0, 32'd0, 32'd0, 1'b1, br(s, 8), addr, tag);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    step(1'b0, 32'd0, 32'd0, 1'b1, br(1, 4), 32'h100, "R1 reset");
    rstN = 1'b1;
    sweep(32'h1000, "R1");
    // equal compare, then or-equal forms
    step(1'b1, 32'h1234, 32'h1234, 1'b0, 16'h0, 32'h0, "R10");
    sweep(32'h2000, "R2");
    for (int s = 6; s < 10; s++) step(1'b0, 0, 0, 1'b1, br(s, -3), 32'h2100, "R5");
    // -1 vs 1: signed less, unsigned greater
    step(1'b1, 32'hFFFF_FFFF, 32'd1, 1'b0, 16'h0, 32'h0, "R3");
    sweep(32'h3000, "R3");
    step(1'b1, 32'd5, 32'd3, 1'b0, 16'h0, 32'h0, "R3");
    sweep(32'h3400, "R4");
    step(1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 16'h0, 32'h0, "R3");
    sweep(32'h3800, "R5");
    // offsets at extremes (flags: sgt false, ugt true)
    step(1'b0, 0, 0, 1'b1, br(5, 511), 32'h4000, "R6");
    step(1'b0, 0, 0, 1'b1, br(5, -512), 32'h4000, "R6");
    step(1'b0, 0, 0, 1'b1, br(5, -1), 32'h4000, "R6");
    step(1'b0, 0, 0, 1'b1, br(5, 16), 32'hFFFF_FFF0, "R6 wrap");
    step(1'b0, 0, 0, 1'b1, br(3, 100), 32'h4000, "R7");
    // illegal selectors, flags must survive
    for (int s = 10; s < 16; s++) step(1'b0, 0, 0, 1'b1, br(s, 7), 32'h5000, "R8");
    sweep(32'h5100, "R8 flags kept");
    step(1'b0, 0, 0, 1'b1, 16'h0000, 32'h6000, "R9");
    step(1'b0, 0, 0, 1'b1, 16'h8000 | 16'(br(0, 2) & 16'h3FFF), 32'h6000, "R9");
    step(1'b0, 0, 0, 1'b1, 16'h4005, 32'h6000, "R9");
    step(1'b0, 0, 0, 1'b0, br(1, 9), 32'h6100, "R10");
    // same-cycle compare and resolve
    step(1'b1, 32'd7, 32'd7, 1'b1, br(0, 6), 32'h7000, "R11 old flags");
    step(1'b0, 0, 0, 1'b1, br(0, 6), 32'h7000, "R11 new flags");
    step(1'b0, 32'd1, 32'd9, 1'b0, 16'h0, 32'h0, "R12");
    step(1'b0, 0, 0, 1'b1, br(0, 6), 32'h7000, "R12");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [15:0] ins;
      a = $urandom_range(0, 3) == 0 ? 32'hFFFF_FFFC + 32'($urandom_range(0, 7)) : 32'($urandom_range(0, 5));
      b = $urandom_range(0, 3) == 0 ? 32'h8000_0000 : 32'($urandom_range(0, 5));
      ins = 16'($urandom);
      if ($urandom_range(0, 4) != 0) ins[15:14] = 2'b11;
      step(1'($urandom), a, b, 1'($urandom_range(0, 3) != 0), ins, $urandom, "R4 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule